// File: doc/BRIEF.md
# Multi-Thread In-Order Retire Controller

This block decides, cycle by cycle, which completed instructions leave the head of a per-thread reorder buffer. It serves one or more hardware threads. The buffer storage sits outside the block. For each thread the buffer presents a small window of its oldest entries, with valid, completed and non-speculative flags for each entry and the sequence number of the head entry. In each cycle one thread retires a contiguous run of completed entries from its head, up to the commit width. The threads take turns at this through a round-robin pointer.

An instruction that must not run speculatively waits at the head of its buffer. When it gets there, the controller broadcasts its thread and sequence number so that earlier stages can issue it. It sends at most one such release per cycle and never sends the same head twice. A fault or interrupt moves the thread into a timed trap wait. After the wait the thread drains until no stores are outstanding. It then raises a squash-all request and sits in a squash state until the buffer reports that the flush is finished. A per-thread strobe tells earlier stages to resend the free-entry count whenever the occupancy of that thread's buffer changes. A registered overall activity flag summarises the thread states.

Top module: `commit_ctrl`

## Requirements
- R1: While rst_ni is low, every thread state reads Idle (0), active_o is 0, and retire_cnt_o, ns_go_o and squash_all_o are all 0.
- R2: The selected thread retires N entries, where N is the number of leading window slots (slot 0 is the head) that are both valid and completed. N is at most COMMIT_WIDTH, and retirement stops at the first slot that is invalid or not completed.
- R3: Thread state encoding is 0 Idle, 1 Running, 2 Squashing, 3 TrapWait, 4 TrapDrain. An Idle thread whose slot 0 is valid enters Running at the next edge. A Running thread whose slot 0 is invalid, with no fault, returns to Idle.
- R4: Only a Running thread with no fault and a completed valid head may retire, and only one thread retires per cycle. Among the eligible threads, the search starts at the thread after the one that retired last.
- R5: A Running thread whose head is valid, non-speculative and not completed causes ns_go_o, with ns_tid_o and ns_seq_o set to that thread and its head sequence number. When several threads qualify, the lowest-numbered thread is released.
- R6: A head that has already been released is not released again until it retires or its thread leaves Running.
- R7: A fault on an Idle or Running thread blocks retirement in that cycle and enters TrapWait. The thread stays in TrapWait for trap_lat_i further edges and enters TrapDrain at the edge after that.
- R8: In TrapDrain, squash_all_o for the thread is high only while stores_pend_i for that thread is low. The thread waits in TrapDrain while stores are pending and enters Squashing at the edge where the request is made.
- R9: A Squashing thread retires nothing and stays Squashing until sq_done_i, then enters Idle.
- R10: free_chg_o for a thread is high in any cycle in which that thread retires, allocates (alloc_i) or is Squashing.
- R11: active_o changes at the same edge as the thread states and is high exactly when at least one thread is not Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hd_vld_i | input | NT x CW | Window slot valid, slot 0 is the head |
| hd_done_i | input | NT x CW | Window slot completed |
| hd_ns_i | input | NT x CW | Window slot non-speculative |
| hd_seq_i | input | NT x SEQ_W | Head sequence number per thread |
| fault_i | input | NT | Fault or interrupt per thread |
| stores_pend_i | input | NT | Stores not yet written back |
| trap_lat_i | input | LAT_W | Trap wait length in cycles |
| sq_done_i | input | NT | Buffer flush complete |
| alloc_i | input | NT | Entries inserted this cycle |
| retire_cnt_o | output | CNT_W | Entries retired this cycle |
| retire_tid_o | output | TID_W | Thread that retires |
| ns_go_o | output | 1 | Non-speculative release strobe |
| ns_seq_o | output | SEQ_W | Released sequence number |
| ns_tid_o | output | TID_W | Released thread |
| squash_all_o | output | NT | Squash-all request |
| thr_state_o | output | NT x 3 | Per-thread state |
| free_chg_o | output | NT | Resend free-entry count |
| active_o | output | 1 | Any thread active |

## Verification
The retire count is driven with window patterns in which the first incomplete slot lies at each position in turn: all slots done, a gap at the head, a gap in the middle, and a valid bit running out before the done bits. These patterns separate a correct stop-at-first-gap count from a population count of done slots and from a count that ignores the valid bits. With two threads both eligible, the winner alternates, which shows the pointer rotates. Two threads with non-speculative heads show both the lowest-index priority and the one-shot release. A trap with latency 2 and stores pending shows the exact edge on which TrapDrain is entered, and shows that the squash request waits for the stores.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  typedef enum logic [2:0] {
    TS_IDLE       = 3'd0,
    TS_RUN        = 3'd1,
    TS_SQUASH     = 3'd2,
    TS_TRAP_WAIT  = 3'd3,
    TS_TRAP_DRAIN = 3'd4
  } thr_st_e;
endpackage

// File: rtl/cmt_thread_fsm.sv
module cmt_thread_fsm
  import cmt_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             head_vld_i,
  input  logic             fault_i,
  input  logic             stores_pend_i,
  input  logic [LAT_W-1:0] trap_lat_i,
  input  logic             sq_done_i,
  output thr_st_e          state_o,
  output thr_st_e          state_d_o,
  output logic             squash_o
);
  thr_st_e          st_q, st_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    squash_o = 1'b0;
    unique case (st_q)
      TS_IDLE, TS_RUN: begin
        if (fault_i) begin
          st_d  = TS_TRAP_WAIT;
          cnt_d = trap_lat_i;
        end else if (head_vld_i) st_d = TS_RUN;
        else                     st_d = TS_IDLE;
      end
      TS_TRAP_WAIT: begin
        if (cnt_q == '0) st_d = TS_TRAP_DRAIN;
        else             cnt_d = cnt_q - 1'b1;
      end
      TS_TRAP_DRAIN: begin
        if (!stores_pend_i) begin
          squash_o = 1'b1;
          st_d     = TS_SQUASH;
        end
      end
      TS_SQUASH: if (sq_done_i) st_d = TS_IDLE;
      default: st_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o   = st_q;
  assign state_d_o = st_d;

  AST_SQUASH_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |=> st_q == TS_SQUASH); // R8
  AST_TRAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TS_TRAP_WAIT && cnt_q != '0) |=> st_q == TS_TRAP_WAIT); // R7
  AST_SQUASH_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TS_SQUASH && !sq_done_i) |=> st_q == TS_SQUASH); // R9
endmodule

// File: rtl/cmt_retire_sel.sv
module cmt_retire_sel #(
  parameter int NT = 2,
  parameter int CW = 4,
  localparam int CNT_W = $clog2(CW + 1),
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NT-1:0]          elig_i,
  input  logic [NT-1:0][CW-1:0]  vld_i,
  input  logic [NT-1:0][CW-1:0]  done_i,
  output logic [CNT_W-1:0]       cnt_o,
  output logic [TID_W-1:0]       tid_o
);
  logic [TID_W-1:0] rr_q;
  logic             found;

  always_comb begin
    found = 1'b0;
    tid_o = '0;
    for (int k = 0; k < NT; k++) begin
      int idx;
      idx = (int'(rr_q) + k) % NT;
      if (!found && elig_i[idx]) begin
        found = 1'b1;
        tid_o = TID_W'(idx);
      end
    end
  end

  // contiguous completed run from head
  always_comb begin
    logic stop;
    stop  = 1'b0;
    cnt_o = '0;
    if (found) begin
      for (int i = 0; i < CW; i++) begin
        if (!stop && vld_i[tid_o][i] && done_i[tid_o][i]) cnt_o = cnt_o + 1'b1;
        else stop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rr_q <= '0;
    else if (cnt_o != '0)   rr_q <= (int'(tid_o) == NT - 1) ? '0 : tid_o + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_o) <= CW); // R2
endmodule

// File: rtl/cmt_ns_release.sv
module cmt_ns_release #(
  parameter int NT    = 2,
  parameter int SEQ_W = 16,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NT-1:0]               cand_i,
  input  logic [NT-1:0]               clr_i,
  input  logic [NT-1:0][SEQ_W-1:0]    seq_i,
  output logic                        go_o,
  output logic [SEQ_W-1:0]            seq_o,
  output logic [TID_W-1:0]            tid_o
);
  logic [NT-1:0] rel_q;

  always_comb begin
    go_o  = 1'b0;
    tid_o = '0;
    for (int t = NT - 1; t >= 0; t--) begin
      if (cand_i[t] && !rel_q[t]) begin
        go_o  = 1'b1;
        tid_o = TID_W'(t);
      end
    end
    seq_o = seq_i[tid_o];
  end

  for (genvar t = 0; t < NT; t++) begin : g_rel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         rel_q[t] <= 1'b0;
      else if (clr_i[t])                   rel_q[t] <= 1'b0;
      else if (go_o && int'(tid_o) == t)   rel_q[t] <= 1'b1;
    end
  end
endmodule

// File: rtl/commit_ctrl.sv
module commit_ctrl
  import cmt_pkg::*;
#(
  parameter int NT    = 2,
  parameter int CW    = 4,
  parameter int SEQ_W = 16,
  parameter int LAT_W = 4,
  localparam int CNT_W = $clog2(CW + 1),
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NT-1:0][CW-1:0]     hd_vld_i,
  input  logic [NT-1:0][CW-1:0]     hd_done_i,
  input  logic [NT-1:0][CW-1:0]     hd_ns_i,
  input  logic [NT-1:0][SEQ_W-1:0]  hd_seq_i,
  input  logic [NT-1:0]             fault_i,
  input  logic [NT-1:0]             stores_pend_i,
  input  logic [LAT_W-1:0]          trap_lat_i,
  input  logic [NT-1:0]             sq_done_i,
  input  logic [NT-1:0]             alloc_i,
  output logic [CNT_W-1:0]          retire_cnt_o,
  output logic [TID_W-1:0]          retire_tid_o,
  output logic                      ns_go_o,
  output logic [SEQ_W-1:0]          ns_seq_o,
  output logic [TID_W-1:0]          ns_tid_o,
  output logic [NT-1:0]             squash_all_o,
  output logic [NT-1:0][2:0]        thr_state_o,
  output logic [NT-1:0]             free_chg_o,
  output logic                      active_o
);
  thr_st_e       st   [NT];
  thr_st_e       st_d [NT];
  logic [NT-1:0] run, elig, cand, clr, busy_d;
  logic          active_q;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    cmt_thread_fsm #(.LAT_W(LAT_W)) u_fsm (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .head_vld_i    (hd_vld_i[t][0]),
      .fault_i       (fault_i[t]),
      .stores_pend_i (stores_pend_i[t]),
      .trap_lat_i    (trap_lat_i),
      .sq_done_i     (sq_done_i[t]),
      .state_o       (st[t]),
      .state_d_o     (st_d[t]),
      .squash_o      (squash_all_o[t])
    );

    assign run[t]  = (st[t] == TS_RUN) && !fault_i[t];
    assign elig[t] = run[t] && hd_vld_i[t][0] && hd_done_i[t][0];
    assign cand[t] = run[t] && hd_vld_i[t][0] && hd_ns_i[t][0] && !hd_done_i[t][0];
    assign clr[t]  = (st[t] != TS_RUN) ||
                     (retire_cnt_o != '0 && int'(retire_tid_o) == t);
    assign busy_d[t]      = (st_d[t] != TS_IDLE);
    assign thr_state_o[t] = st[t];
    assign free_chg_o[t]  = alloc_i[t] || (st[t] == TS_SQUASH) ||
                            (retire_cnt_o != '0 && int'(retire_tid_o) == t);
  end

  cmt_retire_sel #(.NT(NT), .CW(CW)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .elig_i (elig),
    .vld_i  (hd_vld_i),
    .done_i (hd_done_i),
    .cnt_o  (retire_cnt_o),
    .tid_o  (retire_tid_o)
  );

  cmt_ns_release #(.NT(NT), .SEQ_W(SEQ_W)) u_ns (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cand_i (cand),
    .clr_i  (clr),
    .seq_i  (hd_seq_i),
    .go_o   (ns_go_o),
    .seq_o  (ns_seq_o),
    .tid_o  (ns_tid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= |busy_d;
  end
  assign active_o = active_q;

  AST_RETIRE_RUN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_cnt_o != '0 |-> thr_state_o[retire_tid_o] == 3'(TS_RUN)); // R4
  AST_NS_RUN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_go_o |-> (thr_state_o[ns_tid_o] == 3'(TS_RUN) && !hd_done_i[ns_tid_o][0])); // R5
  AST_SQUASH_NO_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_all_o & stores_pend_i) == '0); // R8
endmodule

// File: tb/commit_ctrl_tb_top.sv
`timescale 1ns/1ps
module commit_ctrl_tb_top;
  localparam int NT = 2, CW = 4, SEQ_W = 16, LAT_W = 4;

  logic                     clk_i = 1'b0;
  logic                     rst_ni = 1'b0;
  logic [NT-1:0][CW-1:0]    hd_vld_i = '0, hd_done_i = '0, hd_ns_i = '0;
  logic [NT-1:0][SEQ_W-1:0] hd_seq_i = '0;
  logic [NT-1:0]            fault_i = '0, stores_pend_i = '0, sq_done_i = '0, alloc_i = '0;
  logic [LAT_W-1:0]         trap_lat_i = '0;
  logic [2:0]               retire_cnt_o;
  logic [0:0]               retire_tid_o, ns_tid_o;
  logic                     ns_go_o, active_o;
  logic [SEQ_W-1:0]         ns_seq_o;
  logic [NT-1:0]            squash_all_o, free_chg_o;
  logic [NT-1:0][2:0]       thr_state_o;

  int n_run = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  commit_ctrl #(.NT(NT), .CW(CW), .SEQ_W(SEQ_W), .LAT_W(LAT_W)) dut_i (.*);

  // {valid[3:0], done[3:0], expected count}
  localparam logic [11:0] VEC [8] = '{
    {4'b1111, 4'b1111, 4'd4},
    {4'b1111, 4'b0111, 4'd3},
    {4'b1111, 4'b1011, 4'd2},
    {4'b1111, 4'b1101, 4'd1},
    {4'b1111, 4'b1110, 4'd0},
    {4'b0011, 4'b1111, 4'd2},
    {4'b1111, 4'b0000, 4'd0},
    {4'b0111, 4'b0101, 4'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_wait();
    @(posedge clk_i); #1;
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) edge_wait();
    check("R1 state0", thr_state_o[0], 0);
    check("R1 state1", thr_state_o[1], 0);
    check("R1 active", active_o, 0);
    check("R1 retire", retire_cnt_o, 0);
    check("R1 nsgo", ns_go_o, 0);
    check("R1 squash", squash_all_o, 0);
    rst_ni = 1'b1;
    edge_wait();

    // R3 idle -> running
    hd_vld_i[0] = 4'b0001;
    #1 check("R3 idle no retire", retire_cnt_o, 0);
    edge_wait();
    check("R3 running", thr_state_o[0], 1);
    check("R11 active", active_o, 1);

    // R2 table walk on thread 0
    for (int v = 0; v < 8; v++) begin
      hd_vld_i[0]  = VEC[v][11:8];
      hd_done_i[0] = VEC[v][7:4];
      #1;
      check("R2 count", retire_cnt_o, int'(VEC[v][3:0]));
      check("R10 free_chg", free_chg_o[0], VEC[v][3:0] != 0);
      edge_wait();
    end

    // R4 round robin
    hd_vld_i[0] = 4'b0001; hd_done_i[0] = 4'b0000;
    hd_vld_i[1] = 4'b0001; hd_done_i[1] = 4'b0000;
    edge_wait();
    check("R3 t1 running", thr_state_o[1], 1);
    hd_done_i[0] = 4'b0001; hd_done_i[1] = 4'b0001;
    #1 check("R4 first tid", retire_tid_o, 1);
    check("R10 t1 chg", free_chg_o[1], 1);
    check("R10 t0 no chg", free_chg_o[0], 0);
    edge_wait();
    check("R4 second tid", retire_tid_o, 0);
    edge_wait();
    check("R4 third tid", retire_tid_o, 1);
    check("R4 one count", retire_cnt_o, 1);
    edge_wait();

    // R5/R6 non-speculative release
    hd_done_i = '0;
    hd_ns_i[0] = 4'b0001; hd_ns_i[1] = 4'b0001;
    hd_seq_i[0] = 16'd100; hd_seq_i[1] = 16'd200;
    #1 check("R5 go", ns_go_o, 1);
    check("R5 tid lowest", ns_tid_o, 0);
    check("R5 seq", ns_seq_o, 100);
    edge_wait();
    check("R5 go t1", ns_go_o, 1);
    check("R5 tid t1", ns_tid_o, 1);
    check("R5 seq t1", ns_seq_o, 200);
    edge_wait();
    check("R6 no repeat", ns_go_o, 0);
    hd_done_i[0] = 4'b0001;
    #1 check("R6 retire ns", retire_cnt_o, 1);
    edge_wait();
    hd_done_i[0] = 4'b0000; hd_seq_i[0] = 16'd101;
    #1 check("R6 new head go", ns_go_o, 1);
    check("R6 new head seq", ns_seq_o, 101);
    edge_wait();

    // R7/R8/R9 trap sequence on thread 0
    hd_ns_i = '0;
    hd_vld_i[1] = 4'b0000;
    hd_vld_i[0] = 4'b1111; hd_done_i[0] = 4'b1111;
    trap_lat_i = 4'd2; stores_pend_i[0] = 1'b1; fault_i[0] = 1'b1;
    #1 check("R7 fault blocks retire", retire_cnt_o, 0);
    edge_wait();
    fault_i[0] = 1'b0;
    check("R7 trap wait", thr_state_o[0], 3);
    for (int j = 1; j <= 2; j++) begin
      edge_wait();
      check("R7 still wait", thr_state_o[0], 3);
      check("R7 no retire", retire_cnt_o, 0);
    end
    edge_wait();
    check("R7 drain", thr_state_o[0], 4);
    check("R8 held by stores", squash_all_o[0], 0);
    edge_wait();
    check("R8 drain hold", thr_state_o[0], 4);
    stores_pend_i[0] = 1'b0;
    #1 check("R8 squash req", squash_all_o[0], 1);
    edge_wait();
    check("R8 squashing", thr_state_o[0], 2);
    check("R9 no retire", retire_cnt_o, 0);
    check("R10 squash chg", free_chg_o[0], 1);
    hd_vld_i[0] = '0;
    edge_wait();
    check("R9 hold", thr_state_o[0], 2);
    sq_done_i[0] = 1'b1;
    edge_wait();
    sq_done_i[0] = 1'b0;
    check("R9 idle", thr_state_o[0], 0);
    check("R11 inactive", active_o, 0);

    // R10 allocation on idle thread
    alloc_i[1] = 1'b1;
    #1 check("R10 alloc", free_chg_o[1], 1);
    alloc_i[1] = 1'b0;
    edge_wait();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule